// File: doc/BRIEF.md
# Left-justified stereo serial audio port

This block is the converter-side end of a three-wire stereo sample link for a 16-bit codec. A word-select line splits each frame into a left half (word select high) and a right half (word select low), and a bit clock paces the bits. In every half the port sends one 16-bit two's-complement sample on its serial output and receives one on its serial input. Both words start with the most significant bit, and that bit lines up with the word-select transition; no spare bit comes first. The link needs at least 32 bit clocks per frame and normally runs at 64. Bit slots after the sixteenth in a half carry nothing the port uses.

On the parallel side, the ADC path supplies a left and a right word. The port samples both at the start of every frame and marks that moment with a one-cycle strobe. The DAC path receives the left and right words of a finished frame together, with a one-cycle valid pulse. A force-zero input from the reset and power controller holds the serial output low. A monitor times the high and low phases of word select and asks for a resynchronising reset when the duty cycle leaves the 45 % to 55 % window. All three serial lines are oversampled by a faster system clock through two-stage synchronisers.

Top module: `mj_audio_port`

## Requirements
- R1: At each word-select transition the serial output presents bit 15 of the new half's word, and each later bit-clock rising edge moves it on one bit (15, 14, ... 0). Word select high (1) carries the left word and low (0) carries the right word.
- R2: In bit slots 16 and up of a half, the serial output is 0 and the serial input has no effect on the received words.
- R3: The serial input is sampled on bit-clock rising edges, first bit into bit 15. A word-select transition restarts the word. If a half ends after k < 16 bits, the stored word holds those k bits in its top k positions and zeros below them.
- R4: At each word-select rising edge that follows a completed left half, the received left and right words appear together on the DAC outputs with a valid pulse one system clock long. The first rising edge after reset gives no pulse.
- R5: While force-zero is 1, the serial output is 0 from the next system clock on. Reception is not affected.
- R6: Both ADC words are sampled at the word-select rising edge, with a one-cycle taken strobe. A change to the ADC inputs later in the frame does not alter the bits sent in that frame.
- R7: At each word-select rising edge that closes a fully measured period, the port raises a one-cycle resync request if high×100 < 45×period or high×100 > 55×period, with times counted in system clocks. Exactly 45 % and exactly 55 % are accepted.
- R8: After reset the serial output, the DAC words and all strobes are 0, and the first word-select rising edge raises no resync request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_clk_in | input | 1 | Serial bit clock |
| word_sel_in | input | 1 | Word select: 1 = left half, 0 = right half |
| rx_data_in | input | 1 | Serial DAC data in |
| force_zero | input | 1 | Holds the serial output at 0 |
| adc_left | input | WORD_W | Left ADC sample |
| adc_right | input | WORD_W | Right ADC sample |
| adc_taken | output | 1 | Pulse: ADC words sampled at frame start |
| tx_data_out | output | 1 | Serial ADC data out |
| dac_left | output | WORD_W | Last received left word |
| dac_right | output | WORD_W | Last received right word |
| dac_valid | output | 1 | Pulse: new DAC pair available |
| resync_req | output | 1 | Pulse: word-select duty out of bounds |

## Verification
The assertions check on every cycle that force-zero clears the output on the next clock and that the valid, taken and resync strobes last one cycle and occur only at a word-select rising edge. They also check that the held right ADC word changes only at a frame start and that the receive shifter stays still once a half is full. Only the bench's frame sequences can show the bit order and alignment, partial-word justification after a short half, that mid-frame ADC changes are ignored, and the duty verdict at and around the 45 % and 55 % bounds. For these the bench computes the expected words and the expected request count from the slot counts it drives.

// File: rtl/mj_audio_port.sv
module mj_audio_port #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 16,
  parameter int LO_PCT = 45,
  parameter int HI_PCT = 55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_clk_in,
  input  logic              word_sel_in,
  input  logic              rx_data_in,
  input  logic              force_zero,
  input  logic [WORD_W-1:0] adc_left,
  input  logic [WORD_W-1:0] adc_right,
  output logic              adc_taken,
  output logic              tx_data_out,
  output logic [WORD_W-1:0] dac_left,
  output logic [WORD_W-1:0] dac_right,
  output logic              dac_valid,
  output logic              resync_req
);
  localparam int BIT_W = $clog2(WORD_W + 1);
  localparam int PW    = CNT_W + 8;

  logic [2:0] bck_s, ws_s, din_s;
  logic bck_rise, ws_rise, ws_fall, ws_edge, din;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bck_s <= '0;
      ws_s  <= '0;
      din_s <= '0;
    end else begin
      bck_s <= {bck_s[1:0], bit_clk_in};
      ws_s  <= {ws_s[1:0], word_sel_in};
      din_s <= {din_s[1:0], rx_data_in};
    end
  end

  assign bck_rise = bck_s[1] & ~bck_s[2];
  assign ws_rise  = ws_s[1] & ~ws_s[2];
  assign ws_fall  = ~ws_s[1] & ws_s[2];
  assign ws_edge  = ws_rise | ws_fall;
  assign din      = din_s[1];

  logic [BIT_W-1:0]  cnt;
  logic [WORD_W-1:0] tx_sh, hold_r, rx_sh, rx_just, left_word;
  logic              have_left;

  assign rx_just = rx_sh << (BIT_W'(WORD_W) - cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= BIT_W'(WORD_W);
      tx_sh     <= '0;
      hold_r    <= '0;
      rx_sh     <= '0;
      left_word <= '0;
      have_left <= 1'b0;
      dac_left  <= '0;
      dac_right <= '0;
      dac_valid <= 1'b0;
      adc_taken <= 1'b0;
    end else begin
      dac_valid <= 1'b0;
      adc_taken <= ws_rise;
      if (ws_edge) begin
        cnt   <= '0;
        rx_sh <= '0;
        if (ws_rise) begin
          tx_sh  <= adc_left;
          hold_r <= adc_right;
          if (have_left) begin
            dac_left  <= left_word;
            dac_right <= rx_just;
            dac_valid <= 1'b1;
          end
        end else begin
          tx_sh     <= hold_r;
          left_word <= rx_just;
          have_left <= 1'b1;
        end
      end else if (bck_rise) begin
        tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
        if (cnt < BIT_W'(WORD_W)) begin
          cnt   <= cnt + BIT_W'(1);
          rx_sh <= {rx_sh[WORD_W-2:0], din};
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tx_data_out <= 1'b0;
    else        tx_data_out <= tx_sh[WORD_W-1] & ~force_zero;
  end

  logic [CNT_W-1:0] run_cnt, hi_len;
  logic             seen_rise, hi_ok;
  logic [PW-1:0]    hi_x, period, lim_lo, lim_hi;
  logic             duty_bad;

  assign hi_x     = PW'(hi_len) * PW'(100);
  assign period   = PW'(hi_len) + PW'(run_cnt);
  assign lim_lo   = period * PW'(LO_PCT);
  assign lim_hi   = period * PW'(HI_PCT);
  assign duty_bad = (hi_x < lim_lo) || (hi_x > lim_hi);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt    <= '0;
      hi_len     <= '0;
      seen_rise  <= 1'b0;
      hi_ok      <= 1'b0;
      resync_req <= 1'b0;
    end else begin
      resync_req <= ws_rise & hi_ok & duty_bad;
      if (ws_edge) begin
        run_cnt <= CNT_W'(1);
        if (ws_rise) seen_rise <= 1'b1;
        if (ws_fall) begin
          hi_len <= run_cnt;
          hi_ok  <= seen_rise;
        end
      end else if (run_cnt != '1) begin
        run_cnt <= run_cnt + CNT_W'(1);
      end
    end
  end

  a_r5_force_clears: assert property (@(posedge clk) disable iff (!rst_n)
    force_zero |=> !tx_data_out);
  a_r4_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    dac_valid |=> !dac_valid);
  a_r4_valid_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
    dac_valid |-> $past(ws_rise));
  a_r6_taken_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
    adc_taken |-> $past(ws_rise));
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !ws_rise |=> $stable(hold_r));
  a_r2_rx_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == BIT_W'(WORD_W) && !ws_edge) |=> $stable(rx_sh));
  a_r7_req_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
    resync_req |-> $past(ws_rise));
  a_r7_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    resync_req |=> !resync_req);
endmodule

// File: tb/mj_audio_port_test.sv
module mj_audio_port_test;
  localparam int H = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_clk_in = 1'b1, word_sel_in = 1'b0, rx_data_in = 1'b0, force_zero = 1'b0;
  logic [15:0] adc_left = '0, adc_right = '0;
  logic adc_taken, tx_data_out, dac_valid, resync_req;
  logic [15:0] dac_left, dac_right;

  always #10 clk = ~clk;

  mj_audio_port uut (
    .clk(clk), .rst_n(rst_n), .bit_clk_in(bit_clk_in), .word_sel_in(word_sel_in),
    .rx_data_in(rx_data_in), .force_zero(force_zero), .adc_left(adc_left),
    .adc_right(adc_right), .adc_taken(adc_taken), .tx_data_out(tx_data_out),
    .dac_left(dac_left), .dac_right(dac_right), .dac_valid(dac_valid),
    .resync_req(resync_req));

  int total = 0, bad = 0;
  int vcnt = 0, reqcnt = 0, tcnt = 0;
  logic [15:0] last_l = '0, last_r = '0;
  int exp_valid = 0, exp_req = 0, frames = 0;
  logic [15:0] exp_dl = '0, exp_dr = '0, prev_l = '0, prev_r = '0;
  logic have_prev = 1'b0, prev_bad = 1'b0, done = 1'b0;

  always @(negedge clk) begin
    if (dac_valid) begin vcnt++; last_l = dac_left; last_r = dac_right; end
    if (resync_req) reqcnt++;
    if (adc_taken) tcnt++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] top_mask(input int n);
    return (n >= 16) ? 16'hFFFF : 16'(16'hFFFF << (16 - n));
  endfunction

  task automatic run_frame(input logic [15:0] sl, input logic [15:0] sr,
                           input logic [15:0] al, input logic [15:0] ar,
                           input int nl, input int nr, input logic fz, input logic tear);
    logic [15:0] got, expw, inw;
    logic tail_bad;
    int n;
    adc_left = al;
    adc_right = ar;
    force_zero = fz;
    if (have_prev) begin
      exp_valid++;
      exp_dl = prev_l;
      exp_dr = prev_r;
      if (prev_bad) exp_req++;
    end
    frames++;
    for (int h = 0; h < 2; h++) begin
      n = h ? nr : nl;
      inw = h ? sr : sl;
      expw = fz ? 16'h0 : (h ? ar : al);
      got = '0;
      tail_bad = 1'b0;
      for (int b = 0; b < n; b++) begin
        word_sel_in = (h == 0);
        bit_clk_in = 1'b0;
        rx_data_in = (b < 16) ? inw[15 - b] : 1'b1;
        if (tear && h == 0 && b == 8) begin
          adc_left = ~al;
          adc_right = ~ar;
        end
        repeat (H) @(negedge clk);
        if (b < 16) got[15 - b] = tx_data_out;
        else if (tx_data_out) tail_bad = 1'b1;
        bit_clk_in = 1'b1;
        repeat (H) @(negedge clk);
      end
      check(h ? "R1 R5 R6 right word sent" : "R1 R5 R6 left word sent",
            {16'h0, got}, {16'h0, expw & top_mask(n)});
      if (n > 16) check("R2 tail slots zero", {31'h0, tail_bad}, 32'h0);
    end
    prev_l = sl & top_mask(nl);
    prev_r = sr & top_mask(nr);
    prev_bad = (nl * 100 < 45 * (nl + nr)) || (nl * 100 > 55 * (nl + nr));
    have_prev = 1'b1;
  endtask

  task automatic verify(input string tag);
    check({"R4 valid count ", tag}, vcnt, exp_valid);
    check({"R3 R4 left word ", tag}, {16'h0, last_l}, {16'h0, exp_dl});
    check({"R3 R4 right word ", tag}, {16'h0, last_r}, {16'h0, exp_dr});
    check({"R7 resync count ", tag}, reqcnt, exp_req);
    check({"R6 taken count ", tag}, tcnt, frames);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 reset sdo", {31'h0, tx_data_out}, 32'h0);
    check("R8 reset valid", {31'h0, dac_valid}, 32'h0);
    check("R8 reset resync", {31'h0, resync_req}, 32'h0);
    check("R8 reset dac", {dac_left, dac_right}, 32'h0);

    run_frame(16'hA55A, 16'h0FF1, 16'h8001, 16'h7FFE, 32, 32, 1'b0, 1'b0);
    verify("R8 first frame");

    for (int i = 0; i < 10; i++) begin
      int n = (i % 3 == 0) ? 16 : ((i % 3 == 1) ? 32 : 24);
      run_frame(16'(i * 16'h2F1B + 16'h8001), 16'(i * 16'h0B57 + 16'h7FFF),
                16'(i * 16'h1357 + 16'h4002), 16'(~(i * 16'h3C3D)), n, n, 1'b0, 1'b0);
      verify("sweep");
    end

    run_frame(16'h1234, 16'hFEDC, 16'hFFFF, 16'hFFFF, 32, 32, 1'b1, 1'b0);
    verify("R5 force zero");
    run_frame(16'h0F0F, 16'hF0F0, 16'hC3A5, 16'h5A3C, 32, 32, 1'b0, 1'b1);
    verify("R6 mid-frame change");

    run_frame(16'hBEEF, 16'hCAFE, 16'h9ABC, 16'h1357, 10, 16, 1'b0, 1'b0);
    verify("R3 short left");
    run_frame(16'hFFFF, 16'hFFFF, 16'h2468, 16'hACE1, 16, 7, 1'b0, 1'b0);
    verify("R3 short right");

    run_frame(16'h1111, 16'h2222, 16'h3333, 16'h4444, 36, 28, 1'b0, 1'b0);
    verify("R7 56pct");
    run_frame(16'h5555, 16'h6666, 16'h7777, 16'h8888, 35, 29, 1'b0, 1'b0);
    verify("R7 54pct");
    run_frame(16'h9999, 16'hAAAA, 16'hBBBB, 16'hCCCC, 44, 36, 1'b0, 1'b0);
    verify("R7 55pct");
    run_frame(16'hDDDD, 16'hEEEE, 16'h0001, 16'h8000, 45, 35, 1'b0, 1'b0);
    verify("R7 56pct b");
    run_frame(16'h0102, 16'h0304, 16'h0506, 16'h0708, 36, 44, 1'b0, 1'b0);
    verify("R7 45pct");
    run_frame(16'h090A, 16'h0B0C, 16'h0D0E, 16'h0F10, 28, 36, 1'b0, 1'b0);
    verify("R7 44pct");
    run_frame(16'h7FFF, 16'h8000, 16'h0000, 16'hFFFF, 32, 32, 1'b0, 1'b0);
    verify("R7 after low");
    run_frame(16'h0000, 16'h0000, 16'h0000, 16'h0000, 32, 32, 1'b0, 1'b0);
    verify("final");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule